// File: doc/BRIEF.md
# Unaligned DMA Address Generator

This block produces the bus address and the access width for a single DMA channel on a 32-bit system bus. The buffer it walks may start and end on any byte. Software first loads a start address and a byte count while the channel is stopped. It then writes the control word with the enable bit set. From that point the block presents one access at a time. Each access is a byte count of 1 to 4 and a byte-lane mask. The block advances its live address in the cycle after the bus reports that the address phase of the current access has finished.

Accesses are full words in the middle of the buffer. They are narrower at the leading edge when the start is not word aligned, and at the trailing edge when the remaining count is smaller than a word. The channel stops on its own when the count is used up. If the early-stop option was set in the last control write, an external end-of-transfer strobe also stops it. Address and count stay where the transfer left them, so a later enable resumes from the next unread byte. A done flag records completion until software clears it or starts the channel again.

The controller has three states:
- `ST_IDLE`: stopped, nothing pending.
- `ST_XFER`: running.
- `ST_DONE`: stopped after completion.

Transitions:
- `ST_IDLE`→`ST_XFER` on an enable with a non-zero count.
- `ST_IDLE`→`ST_DONE` and `ST_DONE`→`ST_DONE` on an enable with a zero count.
- `ST_XFER`→`ST_DONE` on the final address phase or an accepted early stop.
- `ST_XFER`→`ST_IDLE` on a control write with the enable bit clear (abort).
- `ST_DONE`→`ST_IDLE` on a done-clear strobe.
- `ST_DONE`→`ST_XFER` on a new enable with a non-zero count.

The count must be written at least one cycle before the enable.

Top module: `dma_edge_addr_gen`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the next cycle shows `cur_addr` = 0, `chan_en` = 0, `done` = 0 and `acc_valid` = 0. The internal remaining count is also 0.
- R2: While `chan_en` is low, a `cfg_wr_addr` strobe loads any byte address, aligned or not, and `cur_addr` shows it in the next cycle. A `cfg_wr_len` strobe under the same condition loads the remaining byte count.
- R3: While `chan_en` is high, `cfg_wr_addr` and `cfg_wr_len` strobes are ignored. The address and the total number of bytes walked are unchanged.
- R4: While `chan_en` is high, `acc_valid` is 1 and `acc_size` is min(4 − `cur_addr[1:0]`, remaining). `acc_lanes` bit i is set exactly for i from `cur_addr[1:0]` to `cur_addr[1:0]` + `acc_size` − 1, with bit 0 being the lowest byte address. Outside a transfer `acc_valid`, `acc_size` and `acc_lanes` are 0.
- R5: In the cycle after `aph_done` is sampled high while running, `cur_addr` has grown by the `acc_size` of that access. Without `aph_done` it holds.
- R6: In the cycle after the address phase that uses up the count, `chan_en` is 0 and `done` is 1.
- R7: `done` stays high until `cfg_clr_done` is strobed or a new enable is written.
- R8: If `eot_req` is sampled high while running and the last control write set the early-stop bit, the next cycle shows `chan_en` = 0 and `done` = 1. `cur_addr` then points to the next unread byte.
- R9: If the last control write left the early-stop bit clear, `eot_req` has no effect and the transfer runs to the end of the buffer.
- R10: An enable written while the remaining count is 0 sets `done` in the next cycle without raising `chan_en`.
- R11: An enable after an early stop resumes at the held address with the held remaining count.
- R12: A control write with the enable bit clear while running stops the channel in the next cycle with `done` left at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_addr | input | 1 | Strobe to load the address register |
| cfg_addr_data | input | 32 | Start address value |
| cfg_wr_len | input | 1 | Strobe to load the remaining byte count |
| cfg_len_data | input | 16 | Byte count value |
| cfg_wr_ctrl | input | 1 | Strobe to write the control word |
| cfg_en_data | input | 1 | Control word: enable bit |
| cfg_eot_en_data | input | 1 | Control word: allow early stop on `eot_req` |
| cfg_clr_done | input | 1 | Strobe to clear the done flag |
| eot_req | input | 1 | External end-of-transfer indication |
| aph_done | input | 1 | Address phase of the presented access has finished |
| cur_addr | output | 32 | Live address of the next byte to access |
| acc_valid | output | 1 | An access is being presented |
| acc_size | output | 3 | Bytes in the presented access, 1 to 4 |
| acc_lanes | output | 4 | Byte-lane enables of the presented access |
| chan_en | output | 1 | Channel running |
| done | output | 1 | Transfer completed |

## Verification
A wrong remaining count inside the block first shows at the ports as a wrong `acc_size` on the final access. It can also show as `done` rising one access too early or too late. Either appears within one address phase of the fault. A wrong offset shows at once as a lane mask that does not start at `cur_addr[1:0]` or a size that crosses a word boundary. A controller stuck in the wrong state shows in the cycle after the triggering strobe as `chan_en` and `done` at the wrong levels. Because stopped and resumed transfers must join seamlessly, an address that drifts during a stop is exposed on the first access after re-enable.

// File: rtl/dmaag_pkg.sv
package dmaag_pkg;

    // Channel controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } chan_state_e;

endpackage

// File: rtl/dmaag_size_calc.sv
// Access width and byte-lane mask for the access at the current offset.
module dmaag_size_calc #(
    parameter int BUS_BYTES = 4,
    parameter int LEN_W     = 16,
    localparam int OFS_W    = $clog2(BUS_BYTES),
    localparam int SZ_W     = OFS_W + 1
) (
    input  logic [OFS_W-1:0]     ofs,
    input  logic [LEN_W-1:0]     rem,
    output logic [SZ_W-1:0]      size,
    output logic [BUS_BYTES-1:0] lanes
);

    logic [SZ_W-1:0] room;
    logic [SZ_W:0]   lane_hi;

    // Bytes left in the current word, starting from the offset
    assign room = SZ_W'(BUS_BYTES) - SZ_W'(ofs);

    always_comb begin
        if (rem < LEN_W'(room)) begin
            size = rem[SZ_W-1:0];
        end else begin
            size = room;
        end
    end

    assign lane_hi = (SZ_W+1)'(ofs) + (SZ_W+1)'(size);

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        assign lanes[i] = ((SZ_W+1)'(i) >= (SZ_W+1)'(ofs)) &&
                          ((SZ_W+1)'(i) <  lane_hi);
    end

endmodule

// File: rtl/dmaag_ptr_regs.sv
// Address and remaining-count registers with the write lock.
module dmaag_ptr_regs #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int SZ_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_ok,
    input  logic              wr_addr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_len,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              step,
    input  logic [SZ_W-1:0]   step_size,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LEN_W-1:0]  rem_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(step_size);
        end else if (load_ok && wr_addr) begin
            addr_q <= addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (step) begin
            rem_q <= rem_q - LEN_W'(step_size);
        end else if (load_ok && wr_len) begin
            rem_q <= len_in;
        end
    end

endmodule

// File: rtl/dmaag_chan_fsm.sv
// Channel controller: run / stop / done sequencing and early-stop option.
module dmaag_chan_fsm
    import dmaag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ctrl,
    input  logic        en_data,
    input  logic        eot_en_data,
    input  logic        clr_done,
    input  logic        eot_req,
    input  logic        step,
    input  logic        last_step,
    input  logic        rem_zero,
    output chan_state_e state_q,
    output logic        eot_en_q,
    output logic        running,
    output logic        finished
);

    chan_state_e state_d;
    logic        start;
    logic        abort;
    logic        eot_hit;

    assign start   = wr_ctrl && en_data;
    assign abort   = wr_ctrl && !en_data;
    assign eot_hit = eot_req && eot_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            eot_en_q <= 1'b0;
        end else if (wr_ctrl) begin
            eot_en_q <= eot_en_data;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = rem_zero ? ST_DONE : ST_XFER;
                end
            end
            ST_XFER: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if ((step && last_step) || eot_hit) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (start) begin
                    state_d = rem_zero ? ST_DONE : ST_XFER;
                end else if (clr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        running  = 1'b0;
        finished = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: running  = 1'b1;
            ST_DONE: finished = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_edge_addr_gen.sv
// Top: unaligned DMA address and access-width generator.
module dma_edge_addr_gen
    import dmaag_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int BUS_BYTES = 4,
    localparam int OFS_W    = $clog2(BUS_BYTES),
    localparam int SZ_W     = OFS_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr_addr,
    input  logic [ADDR_W-1:0]    cfg_addr_data,
    input  logic                 cfg_wr_len,
    input  logic [LEN_W-1:0]     cfg_len_data,
    input  logic                 cfg_wr_ctrl,
    input  logic                 cfg_en_data,
    input  logic                 cfg_eot_en_data,
    input  logic                 cfg_clr_done,
    input  logic                 eot_req,
    input  logic                 aph_done,
    output logic [ADDR_W-1:0]    cur_addr,
    output logic                 acc_valid,
    output logic [SZ_W-1:0]      acc_size,
    output logic [BUS_BYTES-1:0] acc_lanes,
    output logic                 chan_en,
    output logic                 done
);

    chan_state_e          state_q;
    logic                 eot_en_q;
    logic                 running;
    logic                 finished;
    logic [ADDR_W-1:0]    addr_q;
    logic [LEN_W-1:0]     rem_q;
    logic [SZ_W-1:0]      raw_size;
    logic [BUS_BYTES-1:0] raw_lanes;
    logic                 step;
    logic                 last_step;
    logic                 rem_zero;

    assign step      = running && aph_done;
    assign last_step = (rem_q == LEN_W'(raw_size));
    assign rem_zero  = (rem_q == '0);

    dmaag_size_calc #(
        .BUS_BYTES (BUS_BYTES),
        .LEN_W     (LEN_W)
    ) u_size (
        .ofs   (addr_q[OFS_W-1:0]),
        .rem   (rem_q),
        .size  (raw_size),
        .lanes (raw_lanes)
    );

    dmaag_ptr_regs #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .SZ_W   (SZ_W)
    ) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load_ok   (!running),
        .wr_addr   (cfg_wr_addr),
        .addr_in   (cfg_addr_data),
        .wr_len    (cfg_wr_len),
        .len_in    (cfg_len_data),
        .step      (step),
        .step_size (raw_size),
        .addr_q    (addr_q),
        .rem_q     (rem_q)
    );

    dmaag_chan_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .wr_ctrl     (cfg_wr_ctrl),
        .en_data     (cfg_en_data),
        .eot_en_data (cfg_eot_en_data),
        .clr_done    (cfg_clr_done),
        .eot_req     (eot_req),
        .step        (step),
        .last_step   (last_step),
        .rem_zero    (rem_zero),
        .state_q     (state_q),
        .eot_en_q    (eot_en_q),
        .running     (running),
        .finished    (finished)
    );

    assign cur_addr  = addr_q;
    assign chan_en   = running;
    assign done      = finished;
    assign acc_valid = running;
    assign acc_size  = running ? raw_size  : '0;
    assign acc_lanes = running ? raw_lanes : '0;

endmodule

// File: rtl/dmaag_chk.sv
// Property checker, bound to the top module.
module dmaag_chk #(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4,
    localparam int OFS_W    = $clog2(BUS_BYTES),
    localparam int SZ_W     = OFS_W + 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_wr_ctrl,
    input logic                 cfg_clr_done,
    input logic                 eot_req,
    input logic                 eot_en,
    input logic                 aph_done,
    input logic [ADDR_W-1:0]    cur_addr,
    input logic                 acc_valid,
    input logic [SZ_W-1:0]      acc_size,
    input logic [BUS_BYTES-1:0] acc_lanes,
    input logic                 chan_en,
    input logic                 done
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!chan_en && !done && !acc_valid && cur_addr == '0));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !aph_done) |=> (cur_addr == $past(cur_addr)));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && aph_done) |=>
            (cur_addr == $past(cur_addr) + ADDR_W'($past(acc_size))));

    // R4
    lane_count_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (acc_size != '0 && $countones(acc_lanes) == int'(acc_size)));

    // R4
    lane_start_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> acc_lanes[cur_addr[OFS_W-1:0]]);

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (acc_size == '0 && acc_lanes == '0));

    // R6
    run_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(chan_en && done));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !cfg_clr_done && !cfg_wr_ctrl) |=> done);

    // R9
    eot_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && eot_req && !eot_en && !aph_done && !cfg_wr_ctrl) |=> chan_en);

    // R8
    eot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && eot_req && eot_en && !cfg_wr_ctrl) |=> (done && !chan_en));

endmodule

bind dma_edge_addr_gen dmaag_chk #(
    .ADDR_W    (ADDR_W),
    .BUS_BYTES (BUS_BYTES)
) u_dmaag_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr_ctrl  (cfg_wr_ctrl),
    .cfg_clr_done (cfg_clr_done),
    .eot_req      (eot_req),
    .eot_en       (eot_en_q),
    .aph_done     (aph_done),
    .cur_addr     (cur_addr),
    .acc_valid    (acc_valid),
    .acc_size     (acc_size),
    .acc_lanes    (acc_lanes),
    .chan_en      (chan_en),
    .done         (done)
);

// File: tb/test_dma_edge_addr_gen.sv
module test_dma_edge_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_addr;
    logic [31:0] cfg_addr_data;
    logic        cfg_wr_len;
    logic [15:0] cfg_len_data;
    logic        cfg_wr_ctrl;
    logic        cfg_en_data;
    logic        cfg_eot_en_data;
    logic        cfg_clr_done;
    logic        eot_req;
    logic        aph_done;
    logic [31:0] cur_addr;
    logic        acc_valid;
    logic [2:0]  acc_size;
    logic [3:0]  acc_lanes;
    logic        chan_en;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_edge_addr_gen i_dma_edge_addr_gen (
        .clk             (clk),
        .rst             (rst),
        .cfg_wr_addr     (cfg_wr_addr),
        .cfg_addr_data   (cfg_addr_data),
        .cfg_wr_len      (cfg_wr_len),
        .cfg_len_data    (cfg_len_data),
        .cfg_wr_ctrl     (cfg_wr_ctrl),
        .cfg_en_data     (cfg_en_data),
        .cfg_eot_en_data (cfg_eot_en_data),
        .cfg_clr_done    (cfg_clr_done),
        .eot_req         (eot_req),
        .aph_done        (aph_done),
        .cur_addr        (cur_addr),
        .acc_valid       (acc_valid),
        .acc_size        (acc_size),
        .acc_lanes       (acc_lanes),
        .chan_en         (chan_en),
        .done            (done)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int exp_size(input logic [31:0] a, input int rem);
        int room = 4 - int'(a[1:0]);
        return (rem < room) ? rem : room;
    endfunction

    function automatic logic [3:0] exp_lanes(input logic [31:0] a, input int sz);
        logic [3:0] m = '0;
        for (int b = 0; b < 4; b++) begin
            m[b] = (b >= int'(a[1:0])) && (b < int'(a[1:0]) + sz);
        end
        return m;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load(input logic [31:0] a, input int len);
        cfg_wr_addr = 1'b1; cfg_addr_data = a;
        cfg_wr_len = 1'b1; cfg_len_data = 16'(len);
        tick();
        cfg_wr_addr = 1'b0; cfg_wr_len = 1'b0;
    endtask

    task automatic ctrl(input bit en, input bit eoten);
        cfg_wr_ctrl = 1'b1; cfg_en_data = en; cfg_eot_en_data = eoten;
        tick();
        cfg_wr_ctrl = 1'b0; cfg_en_data = 1'b0; cfg_eot_en_data = 1'b0;
    endtask

    // One access: check size and lanes, pulse aph_done, check the advance
    task automatic beat(inout logic [31:0] a, inout int rem, input string rq);
        int sz = exp_size(a, rem);
        chk(acc_valid && acc_size == 3'(sz), {rq, " size R4"}, 32'(acc_size), 32'(sz));
        chk(acc_lanes == exp_lanes(a, sz), {rq, " lanes R4"}, 32'(acc_lanes),
            32'(exp_lanes(a, sz)));
        aph_done = 1'b1;
        tick();
        aph_done = 1'b0;
        a   = a + 32'(sz);
        rem = rem - sz;
        chk(cur_addr == a, {rq, " advance R5"}, cur_addr, a);
    endtask

    task automatic run_out(input logic [31:0] a0, input int rem0, input string rq);
        logic [31:0] a = a0;
        int rem = rem0;
        while (rem > 0) beat(a, rem, rq);
        chk(done && !chan_en && !acc_valid, {rq, " end R6"},
            {29'd0, done, chan_en, acc_valid}, 32'h4);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cfg_wr_addr = 0; cfg_addr_data = 0; cfg_wr_len = 0; cfg_len_data = 0;
        cfg_wr_ctrl = 0; cfg_en_data = 0; cfg_eot_en_data = 0;
        cfg_clr_done = 0; eot_req = 0; aph_done = 0;
        tick(); tick();
        rst = 1'b0;
        chk(cur_addr == 0 && !chan_en && !done && !acc_valid, "R1 reset",
            {cur_addr[27:0], chan_en, done, acc_valid, 1'b0}, 32'h0);
        // R1: remaining count is zero, so an enable completes at once
        ctrl(1'b1, 1'b0);
        chk(done && !chan_en, "R1 count cleared", {30'd0, done, chan_en}, 32'h2);
        cfg_clr_done = 1'b1; tick(); cfg_clr_done = 1'b0;
    endtask

    task automatic t_lock();
        load(32'h0000_0103, 5);
        chk(cur_addr == 32'h103, "R2 unaligned load", cur_addr, 32'h103);
        ctrl(1'b1, 1'b0);
        chk(chan_en, "R2 start", {31'd0, chan_en}, 1);
        cfg_wr_addr = 1'b1; cfg_addr_data = 32'h0000_0ABC;
        cfg_wr_len = 1'b1; cfg_len_data = 16'd40;
        tick();
        cfg_wr_addr = 1'b0; cfg_wr_len = 1'b0;
        chk(cur_addr == 32'h103, "R3 addr locked", cur_addr, 32'h103);
        // R3: the count is unchanged, so the walk ends after 5 bytes
        run_out(32'h103, 5, "R3");
    endtask

    task automatic t_patterns();
        load(32'h0000_2000, 8);  ctrl(1'b1, 1'b0); run_out(32'h2000, 8, "R4 aligned");
        load(32'h0000_3001, 2);  ctrl(1'b1, 1'b0); run_out(32'h3001, 2, "R4 inner");
        load(32'h0000_4002, 1);  ctrl(1'b1, 1'b0); run_out(32'h4002, 1, "R4 single");
        load(32'h0000_5003, 10); ctrl(1'b1, 1'b0); run_out(32'h5003, 10, "R4 both edges");
        load(32'h0000_6002, 2);  ctrl(1'b1, 1'b0); run_out(32'h6002, 2, "R4 word tail");
    endtask

    task automatic t_hold();
        logic [31:0] a = 32'h0000_7001;
        int rem = 6;
        load(a, rem); ctrl(1'b1, 1'b0);
        repeat (3) tick();
        chk(cur_addr == a && chan_en, "R5 hold without phase", cur_addr, a);
        while (rem > 0) beat(a, rem, "R5");
        repeat (4) tick();
        chk(done, "R7 done held", {31'd0, done}, 1);
        cfg_clr_done = 1'b1; tick(); cfg_clr_done = 1'b0;
        chk(!done && !chan_en, "R7 done cleared", {31'd0, done}, 0);
    endtask

    task automatic t_eot();
        logic [31:0] a = 32'h0000_0200;
        int rem = 12;
        load(a, rem); ctrl(1'b1, 1'b0);
        beat(a, rem, "R9");
        eot_req = 1'b1; tick(); eot_req = 1'b0;
        chk(chan_en && !done, "R9 eot ignored", {30'd0, chan_en, done}, 32'h2);
        run_out(a, rem, "R9");
        a = 32'h0000_0301; rem = 10;
        load(a, rem); ctrl(1'b1, 1'b1);
        beat(a, rem, "R8");
        eot_req = 1'b1; tick(); eot_req = 1'b0;
        chk(done && !chan_en, "R8 early stop", {30'd0, done, chan_en}, 32'h2);
        chk(cur_addr == 32'h304, "R8 address kept", cur_addr, 32'h304);
        ctrl(1'b1, 1'b0);
        chk(chan_en && !done && cur_addr == 32'h304, "R11 resume",
            cur_addr, 32'h304);
        run_out(32'h304, 7, "R11");
    endtask

    task automatic t_zero();
        cfg_clr_done = 1'b1; tick(); cfg_clr_done = 1'b0;
        load(32'h0000_0811, 0);
        ctrl(1'b1, 1'b0);
        chk(done && !chan_en && !acc_valid, "R10 zero length",
            {29'd0, done, chan_en, acc_valid}, 32'h4);
        chk(cur_addr == 32'h811, "R10 no access", cur_addr, 32'h811);
    endtask

    task automatic t_abort();
        logic [31:0] a = 32'h0000_0902;
        int rem = 9;
        load(a, rem); ctrl(1'b1, 1'b0);
        beat(a, rem, "R12");
        ctrl(1'b0, 1'b0);
        chk(!chan_en && !done, "R12 abort", {30'd0, chan_en, done}, 0);
        chk(cur_addr == 32'h904, "R12 address", cur_addr, 32'h904);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        summary();
    end

    initial begin
        t_reset();
        t_lock();
        t_patterns();
        t_hold();
        t_eot();
        t_zero();
        t_abort();
        summary();
    end

endmodule